// File: doc/BRIEF.md
# Dual-Channel Gain and Power Controller

This block drives two amplifier channels. For each channel it produces an attenuation code and an enable. The resulting gain is 26 dB minus 0.25 dB per code step. Codes run from 0 (26 dB) to 80 (6 dB).

A mode input selects where control comes from:

- **Pin mode.** One gain bus and one shutdown pin drive both channels the same way, with no clock delay.
- **Register mode.** The block takes the current contents of four serial-interface registers: power, attenuation A, attenuation B and channel control.
  - Each channel keeps its own code register.
  - That register is reloaded from its source only while the channel's load bit is set.
  - A sync bit makes both channels take the attenuation A value.

The register file and the serial shifter sit outside this block and only present register values here. The block does not model the analog attenuator.

Top module: `gpc_top`

## Requirements
- R1: Any attenuation code above 80 reaches the channel outputs as 80, in both modes. Codes 0 to 80 pass through unchanged.
- R2: With `ser_mode`=0, both `code_a` and `code_b` equal the clamped `par_code` in the same cycle, whatever the register inputs hold.
- R3: With `ser_mode`=0:
  - `par_shdn`=1 drives `en_a` and `en_b` low.
  - `par_shdn`=0 drives them high.
  - The output codes do not change with `par_shdn`.
- R4: With `ser_mode`=1:
  - `par_shdn` has no effect.
  - `en_a` is high only when `pwr_reg` bits 5 and 3 are both 0.
  - `en_b` is high only when `pwr_reg` bits 4 and 2 are both 0.
- R5: With `ser_mode`=1 and `ctrl_reg` bit 2 (sync) = 1, every channel whose load bit is set takes the clamped `atten_a_reg` value.
- R6: With `ser_mode`=1 and sync = 0, channel A is sourced from `atten_a_reg` and channel B from `atten_b_reg`.
- R7: With `ser_mode`=1, load A (`ctrl_reg` bit 1) and load B (bit 0) work the same way for their own channel:
  - When the load bit is 0, the channel holds its code whatever its source does.
  - When the load bit is 1, the channel shows its clamped source one clock edge later.
- R8: Reset sets both channel code registers to 80. In register mode with both load bits clear, the outputs read 80 after reset.
- R9: The channel code registers are not written in pin mode. A switch to pin mode shows the bus value at once. A switch back to register mode with the load bits clear shows the codes held before the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_mode | input | 1 | 1 = register mode, 0 = pin mode |
| par_code | input | 7 | Pin-mode attenuation code |
| par_shdn | input | 1 | Pin-mode shutdown, 1 = off |
| pwr_reg | input | 4 | Power register bits [5:2], 1 = off |
| atten_a_reg | input | 7 | Attenuation register A code |
| atten_b_reg | input | 7 | Attenuation register B code |
| ctrl_reg | input | 3 | Channel control: bit 2 sync, bit 1 load A, bit 0 load B |
| code_a | output | 7 | Channel A attenuation code |
| code_b | output | 7 | Channel B attenuation code |
| en_a | output | 1 | Channel A enable |
| en_b | output | 1 | Channel B enable |

## Verification
The bench uses codes 81 and 100 to target the clamp boundary. A missing or off-by-one clamp would pass a code outside the 6 dB limit.

It clears one load bit at a time while the source changes. A design that mixed up the load bit positions, or ignored them, would move the wrong channel.

It sets sync with only load A set, to check that channel B still holds. A sync path that bypassed the load gate would break this.

It switches modes both ways. This shows that the pin bus never overwrites the held register codes, and that the shutdown pin has no effect in register mode.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
    localparam int CODE_W    = 7;
    localparam int MAX_CODE  = 80;
    localparam int NUM_CH    = 2;
    localparam int SYNC_BIT  = 2;
    localparam int LOAD_A_BIT = 1;
    localparam int LOAD_B_BIT = 0;

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } chan_st_t;
endpackage

// File: rtl/gpc_clamp.sv
module gpc_clamp #(
    parameter int W   = gpc_pkg::CODE_W,
    parameter int MAX = gpc_pkg::MAX_CODE
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] clamped
);
    localparam logic [W-1:0] LIMIT = W'(MAX);

    always_comb begin
        clamped = (raw > LIMIT) ? LIMIT : raw;
    end
endmodule

// File: rtl/gpc_chan.sv
module gpc_chan
    import gpc_pkg::*;
#(
    parameter int W   = CODE_W,
    parameter int RST = MAX_CODE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] src,
    output logic [W-1:0] code_q
);
    logic [W-1:0] code_d;

    always_comb begin
        code_d = code_q;
        if (upd) begin
            code_d = src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= W'(RST);
        end else begin
            code_q <= code_d;
        end
    end

    // A channel with no update keeps its code
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(code_q));
endmodule

// File: rtl/gpc_power.sv
module gpc_power (
    input  logic       ser_mode,
    input  logic       par_shdn,
    input  logic [5:2] pwr_reg,
    output logic       en_a,
    output logic       en_b
);
    always_comb begin
        if (ser_mode) begin
            en_a = !(pwr_reg[5] | pwr_reg[3]);
            en_b = !(pwr_reg[4] | pwr_reg[2]);
        end else begin
            en_a = !par_shdn;
            en_b = !par_shdn;
        end
    end
endmodule

// File: rtl/gpc_top.sv
module gpc_top
    import gpc_pkg::*;
#(
    parameter int W   = CODE_W,
    parameter int MAX = MAX_CODE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_mode,
    input  logic [W-1:0] par_code,
    input  logic         par_shdn,
    input  logic [5:2]   pwr_reg,
    input  logic [W-1:0] atten_a_reg,
    input  logic [W-1:0] atten_b_reg,
    input  logic [2:0]   ctrl_reg,
    output logic [W-1:0] code_a,
    output logic [W-1:0] code_b,
    output logic         en_a,
    output logic         en_b
);
    localparam logic [W-1:0] LIMIT = W'(MAX);

    logic [W-1:0] par_cl;
    logic [W-1:0] ch_out [NUM_CH];
    logic         sync;

    assign sync = ctrl_reg[SYNC_BIT];

    gpc_clamp #(.W(W), .MAX(MAX)) i_par_clamp (
        .raw     (par_code),
        .clamped (par_cl)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam int LBIT = (ch == 0) ? LOAD_A_BIT : LOAD_B_BIT;
        logic [W-1:0] raw;
        logic [W-1:0] src;
        logic [W-1:0] held;
        logic         upd;

        if (ch == 0) begin : g_a
            assign raw = atten_a_reg;
        end else begin : g_b
            assign raw = sync ? atten_a_reg : atten_b_reg;
        end

        gpc_clamp #(.W(W), .MAX(MAX)) i_clamp (
            .raw     (raw),
            .clamped (src)
        );

        assign upd = ser_mode & ctrl_reg[LBIT];

        gpc_chan #(.W(W), .RST(MAX)) i_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd    (upd),
            .src    (src),
            .code_q (held)
        );

        assign ch_out[ch] = ser_mode ? held : par_cl;
    end

    assign code_a = ch_out[0];
    assign code_b = ch_out[1];

    gpc_power i_power (
        .ser_mode (ser_mode),
        .par_shdn (par_shdn),
        .pwr_reg  (pwr_reg),
        .en_a     (en_a),
        .en_b     (en_b)
    );

    assert_clamp_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
        code_a <= LIMIT);
    assert_clamp_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
        code_b <= LIMIT);
    assert_par_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_mode |-> code_a == code_b);
    assert_par_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode && par_shdn) |-> (!en_a && !en_b));
    assert_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode && sync && ctrl_reg[LOAD_A_BIT] && ctrl_reg[LOAD_B_BIT])
        |=> (ser_mode |-> code_a == code_b));
endmodule

// File: tb/test_gpc_top.sv
module test_gpc_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ser_mode;
    logic [6:0] par_code;
    logic       par_shdn;
    logic [5:2] pwr_reg;
    logic [6:0] atten_a_reg;
    logic [6:0] atten_b_reg;
    logic [2:0] ctrl_reg;
    logic [6:0] code_a;
    logic [6:0] code_b;
    logic       en_a;
    logic       en_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpc_top i_gpc_top (
        .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .par_code(par_code),
        .par_shdn(par_shdn), .pwr_reg(pwr_reg), .atten_a_reg(atten_a_reg),
        .atten_b_reg(atten_b_reg), .ctrl_reg(ctrl_reg), .code_a(code_a),
        .code_b(code_b), .en_a(en_a), .en_b(en_b)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 0; ser_mode = 1; par_code = 0; par_shdn = 0;
        pwr_reg = 0; atten_a_reg = 5; atten_b_reg = 6; ctrl_reg = 3'b000;
        repeat (2) tick();
        chk("R8 code_a in reset", code_a, 80);
        rst_n = 1;
        tick();
        chk("R8 code_a after reset", code_a, 80);
        chk("R8 code_b after reset", code_b, 80);
    endtask

    task automatic t_parallel();
        ser_mode = 0; par_code = 17; atten_a_reg = 3; atten_b_reg = 9;
        #1;
        chk("R2 code_a pin", code_a, 17);
        chk("R2 code_b pin", code_b, 17);
        par_code = 80; #1;
        chk("R1 pin 80", code_a, 80);
        par_code = 81; #1;
        chk("R1 pin 81 clamp", code_b, 80);
        par_code = 127; #1;
        chk("R1 pin 127 clamp", code_a, 80);
    endtask

    task automatic t_par_shdn();
        ser_mode = 0; par_code = 8; par_shdn = 1; pwr_reg = 4'b0000; #1;
        chk("R3 en_a off", en_a, 0);
        chk("R3 en_b off", en_b, 0);
        chk("R3 code kept", code_a, 8);
        par_shdn = 0; #1;
        chk("R3 en_a on", en_a, 1);
        chk("R3 en_b on", en_b, 1);
    endtask

    task automatic t_serial_power();
        ser_mode = 1; par_shdn = 1; pwr_reg = 4'b0000; #1;
        chk("R4 shdn ignored a", en_a, 1);
        chk("R4 shdn ignored b", en_b, 1);
        pwr_reg = 4'b1000; #1;
        chk("R4 bit5 a off", en_a, 0);
        chk("R4 bit5 b on", en_b, 1);
        pwr_reg = 4'b0010; #1;
        chk("R4 bit3 a off", en_a, 0);
        pwr_reg = 4'b0001; #1;
        chk("R4 bit2 b off", en_b, 0);
        chk("R4 bit2 a on", en_a, 1);
        pwr_reg = 4'b0100; #1;
        chk("R4 bit4 b off", en_b, 0);
        pwr_reg = 0; par_shdn = 0;
    endtask

    task automatic t_independent_load();
        ser_mode = 1; ctrl_reg = 3'b011; atten_a_reg = 10; atten_b_reg = 20;
        tick();
        chk("R6 a from reg A", code_a, 10);
        chk("R6 b from reg B", code_b, 20);
        ctrl_reg = 3'b000; atten_a_reg = 30; atten_b_reg = 40;
        tick();
        chk("R7 a hold", code_a, 10);
        chk("R7 b hold", code_b, 20);
        ctrl_reg = 3'b010;
        tick();
        chk("R7 load a only a", code_a, 30);
        chk("R7 load a only b", code_b, 20);
        ctrl_reg = 3'b011; atten_a_reg = 100; atten_b_reg = 81;
        tick();
        chk("R1 reg A clamp", code_a, 80);
        chk("R1 reg B clamp", code_b, 80);
    endtask

    task automatic t_sync();
        ser_mode = 1; ctrl_reg = 3'b111; atten_a_reg = 12; atten_b_reg = 50;
        tick();
        chk("R5 sync a", code_a, 12);
        chk("R5 sync b", code_b, 12);
        ctrl_reg = 3'b110; atten_a_reg = 14;
        tick();
        chk("R5 sync a loads", code_a, 14);
        chk("R7 sync b held", code_b, 12);
    endtask

    task automatic t_mode_switch();
        ser_mode = 1; ctrl_reg = 3'b011; atten_a_reg = 5; atten_b_reg = 6;
        tick();
        chk("R6 pre switch b", code_b, 6);
        ctrl_reg = 3'b000;
        ser_mode = 0; par_code = 40; #1;
        chk("R9 pin at once a", code_a, 40);
        chk("R9 pin at once b", code_b, 40);
        ctrl_reg = 3'b011;
        tick();
        ctrl_reg = 3'b000;
        tick();
        ser_mode = 1; #1;
        chk("R9 back a held", code_a, 5);
        chk("R9 back b held", code_b, 6);
    endtask

    initial begin
        t_reset();
        t_parallel();
        t_par_shdn();
        t_serial_power();
        t_independent_load();
        t_sync();
        t_mode_switch();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule